// File: doc/BRIEF.md
# Bidirectional Sampling-Pulse Shift Register

This block produces the per-column sampling enables for a column driver. A start token enters from one of two cascade pins, waits for the next rising edge of phase clock 1, and then moves along a chain of `COLS` stages. Each stage drives one column enable. The token leaves the far end as a carry pulse on the opposite cascade pin, which starts the next driver in a cascade.

A direction input picks which cascade pin receives the start and which one sends the carry. It also picks the order in which the columns are walked. There are two stepping modes:

- **Grouped mode** (used for stripe panels): each phase-1 rising edge advances the token by a group of three neighbouring columns, and those three columns sample together.
- **Serial mode** (used for delta and mosaic panels): phases 1, 2 and 3 form a three-phase clock, and every rising edge of any phase advances the token by a single column.

All inputs are level signals sampled on the system clock, and every edge is detected synchronously.

Top module: `sp_pulse_chain`

## Requirements
- R1: A low `rst_n` at a clock edge clears every stage, the carry and any pending start. After that edge, `col_pulse`, `casc_l_out` and `casc_r_out` are all 0, and a later phase-1 edge launches nothing until a new start arrives.
- R2: With `dir_fwd`=1, the start is taken from `casc_r_in`. Logical column j appears on `col_pulse[j]`, the carry leaves on `casc_l_out`, `casc_l_oe`=1 and `casc_r_oe`=0. With `dir_fwd`=0, all of these roles swap: the start comes from `casc_l_in`, logical column j appears on `col_pulse[COLS-1-j]`, and the carry leaves on `casc_r_out`. A start level on the pin that is not the input has no effect.
- R3: A token is launched only at a rising edge of `ph1`. This is either the first such edge after a rising edge of the selected start input, or the same cycle as that start edge. A start with no `ph1` edge raises no column.
- R4: With `seq_mode`=0, the k-th phase-1 edge after launch (counting the launch edge as k=1) raises logical columns 3(k-1), 3(k-1)+1 and 3(k-1)+2 together, until the next phase-1 edge. Rising edges of `ph2` and `ph3` change nothing.
- R5: With `seq_mode`=1, each rising edge of `ph1`, `ph2` or `ph3` advances the token by exactly one logical column. Only logical column k-1 is high after the k-th edge.
- R6: A start that stays high across several phase-1 edges launches exactly one token, and at the same phase-1 edge as a one-cycle start.
- R7: The shift event that moves the token out of the last column sets the active cascade output to 1. The next shift event clears it. The inactive cascade output is always 0.
- R8: Every output change caused by a phase or start edge is visible one system clock after the level change is first sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ph1 | input | 1 | Phase clock 1 level (launch and grouped step) |
| ph2 | input | 1 | Phase clock 2 level (serial mode only) |
| ph3 | input | 1 | Phase clock 3 level (serial mode only) |
| dir_fwd | input | 1 | 1: right pin in, walk upward; 0: left pin in, walk downward |
| seq_mode | input | 1 | 0: grouped stepping; 1: serial three-phase stepping |
| casc_r_in | input | 1 | Right cascade pin, input side |
| casc_r_out | output | 1 | Right cascade pin, carry drive |
| casc_r_oe | output | 1 | Right cascade pin output enable |
| casc_l_in | input | 1 | Left cascade pin, input side |
| casc_l_out | output | 1 | Left cascade pin, carry drive |
| casc_l_oe | output | 1 | Left cascade pin output enable |
| col_pulse | output | COLS | Column sampling enables |

## Verification
Two functions can fall in the same cycle: the detection of a start edge and the phase-1 edge that captures it. The bench raises the start input and `ph1` on the same system cycle and expects the token in the first group immediately, with no extra phase-1 edge. It also holds the start high across every phase-1 edge of a sweep, and the expected column vectors, derived from a step count, reveal any second launch. Each sweep covers both directions and both modes on a nine-column configuration.

// File: rtl/sp_pkg.sv
// Shared constants and types for the sampling-pulse chain.
// Assumes a fixed group of three colour columns and three phase clocks.
package sp_pkg;
    localparam int unsigned PHASES = 3;
    localparam int unsigned GROUP  = 3;

    typedef enum logic {
        SAMPLE_GROUPED = 1'b0,
        SAMPLE_SERIAL  = 1'b1
    } sample_mode_e;
endpackage

// File: rtl/sp_edge.sv
// Synchronous rising-edge detector for W independent level inputs.
// Assumes the inputs are already synchronous to clk; reset treats every input as previously low.
module sp_edge #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_chk
            // R8
            rise_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[gi] |=> !rise_o[gi]);
        end
    endgenerate
endmodule

// File: rtl/sp_launch.sv
// Holds a detected start edge until the next phase-1 edge and issues one launch there.
// Assumes start_rise_i and ph1_rise_i are single-cycle edge strobes.
module sp_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rise_i,
    input  logic ph1_rise_i,
    output logic launch_o
);
    logic pending_q;

    assign launch_o = ph1_rise_i & (pending_q | start_rise_i);

    // Keep a start pending until a phase-1 edge consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)          pending_q <= 1'b0;
        else if (ph1_rise_i) pending_q <= 1'b0;
        else if (start_rise_i) pending_q <= 1'b1;
    end

    // R3
    start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rise_i && !ph1_rise_i |=> pending_q);
    // R6
    single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !pending_q);
endmodule

// File: rtl/sp_chain.sv
// Column token chain in logical order (stage 0 is sampled first).
// Grouped stepping moves GRP stages per shift; serial stepping moves one.
// Assumes COLS is a multiple of GRP and larger than GRP.
module sp_chain #(
    parameter int unsigned COLS = 240,
    parameter int unsigned GRP  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_i,
    input  logic            grouped_i,
    input  logic            launch_i,
    output logic [COLS-1:0] stage_o,
    output logic            carry_o
);
    localparam int unsigned TOP = COLS - 1;

    logic [COLS-1:0] stage_q;
    logic [COLS-1:0] stage_d;
    logic            carry_q;

    // Next chain contents for the selected step size.
    always_comb begin
        if (grouped_i) stage_d = {stage_q[COLS-GRP-1:0], {GRP{launch_i}}};
        else           stage_d = {stage_q[COLS-2:0], launch_i};
    end

    // Advance the chain on each shift event.
    always_ff @(posedge clk) begin
        if (!rst_n)       stage_q <= '0;
        else if (shift_i) stage_q <= stage_d;
    end

    // Carry is set by the shift that empties the last stage, cleared by the next.
    always_ff @(posedge clk) begin
        if (!rst_n)       carry_q <= 1'b0;
        else if (shift_i) carry_q <= stage_q[TOP];
    end

    assign stage_o = stage_q;
    assign carry_o = carry_q;

    // R3
    first_stage_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_q[0]) |-> $past(launch_i));
    // R7
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q && !shift_i |=> carry_q);
    // R7
    carry_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_q) |-> $past(stage_q[TOP]));
endmodule

// File: rtl/sp_pulse_chain.sv
// Top: bidirectional sampling-pulse generator with grouped or serial stepping.
// Assumes all inputs are synchronous to clk and COLS is a multiple of three.
// The cascade pins are split into in/out/oe for a pad wrapper to combine.
module sp_pulse_chain
    import sp_pkg::*;
#(
    parameter int unsigned COLS = 240
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ph1,
    input  logic            ph2,
    input  logic            ph3,
    input  logic            dir_fwd,
    input  logic            seq_mode,
    input  logic            casc_r_in,
    output logic            casc_r_out,
    output logic            casc_r_oe,
    input  logic            casc_l_in,
    output logic            casc_l_out,
    output logic            casc_l_oe,
    output logic [COLS-1:0] col_pulse
);
    sample_mode_e          mode;
    logic [PHASES-1:0]     ph_rise;
    logic                  start_lvl;
    logic                  start_rise;
    logic                  launch;
    logic                  shift;
    logic                  carry;
    logic [COLS-1:0]       stage;

    assign mode      = sample_mode_e'(seq_mode);
    assign start_lvl = dir_fwd ? casc_r_in : casc_l_in;

    sp_edge #(.W(PHASES)) i_ph_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({ph3, ph2, ph1}),
        .rise_o (ph_rise)
    );

    sp_edge #(.W(1)) i_start_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (start_lvl),
        .rise_o (start_rise)
    );

    sp_launch i_launch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_rise_i (start_rise),
        .ph1_rise_i   (ph_rise[0]),
        .launch_o     (launch)
    );

    // Shift events: phase 1 only when grouped, any phase when serial.
    always_comb begin
        if (mode == SAMPLE_SERIAL) shift = |ph_rise;
        else                       shift = ph_rise[0];
    end

    sp_chain #(.COLS(COLS), .GRP(GROUP)) i_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (shift),
        .grouped_i (mode == SAMPLE_GROUPED),
        .launch_i  (launch),
        .stage_o   (stage),
        .carry_o   (carry)
    );

    // Map logical stage order onto physical columns per direction.
    genvar gc;
    generate
        for (gc = 0; gc < COLS; gc++) begin : g_col
            assign col_pulse[gc] = dir_fwd ? stage[gc] : stage[COLS-1-gc];
        end
    endgenerate

    assign casc_l_oe  = dir_fwd;
    assign casc_r_oe  = !dir_fwd;
    assign casc_l_out = dir_fwd & carry;
    assign casc_r_out = !dir_fwd & carry;

    // R4
    grouped_ignores_ph23_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_mode && !ph_rise[0] |=> $stable(col_pulse) || !$stable(dir_fwd));
    // R2
    idle_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(casc_l_out && casc_r_out));
endmodule

// File: tb/test_sp_pulse_chain.sv
// Sweeps both directions, both modes and both start widths on a 9-column chain.
module test_sp_pulse_chain;
    localparam int NC = 9;
    localparam int NG = NC / 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [2:0]    ph = '0;
    logic          dir_fwd = 1'b1, seq_mode = 1'b0;
    logic          r_in = 1'b0, l_in = 1'b0;
    logic          r_out, r_oe, l_out, l_oe;
    logic [NC-1:0] col_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    sp_pulse_chain #(.COLS(NC)) i_sp_pulse_chain (
        .clk(clk), .rst_n(rst_n), .ph1(ph[0]), .ph2(ph[1]), .ph3(ph[2]),
        .dir_fwd(dir_fwd), .seq_mode(seq_mode),
        .casc_r_in(r_in), .casc_r_out(r_out), .casc_r_oe(r_oe),
        .casc_l_in(l_in), .casc_l_out(l_out), .casc_l_oe(l_oe),
        .col_pulse(col_pulse)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected physical vector after s shift events since launch (s=0: none).
    function automatic int exp_vec(int s, bit dir, bit seq);
        logic [NC-1:0] lg = '0;
        logic [NC-1:0] pv = '0;
        if (s > 0) begin
            if (seq) begin
                if (s - 1 < NC) lg[s-1] = 1'b1;
            end else if (s - 1 < NG) begin
                for (int b = 0; b < 3; b++) lg[3*(s-1)+b] = 1'b1;
            end
        end
        for (int i = 0; i < NC; i++) pv[i] = dir ? lg[i] : lg[NC-1-i];
        return int'(pv);
    endfunction

    function automatic int exp_carry(int s, bit seq);
        if (s == 0) return 0;
        return seq ? int'(s - 1 == NC) : int'(s - 1 == NG);
    endfunction

    task automatic check_all(string req, int s);
        int c;
        c = exp_carry(s, seq_mode);
        check(req, "col_pulse", int'(col_pulse), exp_vec(s, dir_fwd, seq_mode));
        check("R7", "active carry", dir_fwd ? int'(l_out) : int'(r_out), c);
        check("R7", "idle carry", dir_fwd ? int'(r_out) : int'(l_out), 0);
        check("R2", "oe pair", int'({l_oe, r_oe}), dir_fwd ? 2 : 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ph = '0; r_in = 1'b0; l_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic step(int p);
        ph[p] = 1'b1;
        @(negedge clk);
        ph[p] = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_start(bit v);
        if (dir_fwd) r_in = v; else l_in = v;
    endtask

    task automatic sweep(bit dir, bit seq, bit wide);
        int total;
        string tag;
        do_reset();
        dir_fwd = dir; seq_mode = seq;
        tag = wide ? "R6" : (seq ? "R5" : "R4");
        @(negedge clk);
        set_start(1'b1);
        @(negedge clk);
        if (!wide) set_start(1'b0);
        @(negedge clk);
        check_all("R3", 0);
        total = (seq ? NC : NG) + 2;
        for (int i = 0; i < total; i++) begin
            step(seq ? (i % 3) : 0);
            check_all(tag, i + 1);
            if (!seq) begin
                step(1);
                step(2);
                check_all("R4", i + 1);
            end
        end
        set_start(1'b0);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        do_reset();
        check_all("R1", 0);

        for (int d = 0; d < 2; d++)
            for (int m = 0; m < 2; m++)
                for (int w = 0; w < 2; w++)
                    sweep(d[0], m[0], w[0]);

        // R2: start on the output-side pin is ignored
        do_reset();
        dir_fwd = 1'b1; seq_mode = 1'b0;
        l_in = 1'b1; @(negedge clk); l_in = 1'b0; @(negedge clk);
        step(0);
        check("R2", "wrong pin start", int'(col_pulse), 0);
        dir_fwd = 1'b0;
        @(negedge clk);
        r_in = 1'b1; @(negedge clk); r_in = 1'b0; @(negedge clk);
        step(0);
        check("R2", "wrong pin start rev", int'(col_pulse), 0);

        // R3 + R8: start edge and phase-1 edge in the same cycle
        do_reset();
        dir_fwd = 1'b1; seq_mode = 1'b0;
        @(negedge clk);
        r_in = 1'b1; ph[0] = 1'b1;
        @(negedge clk);
        check("R3", "same-cycle launch", int'(col_pulse), exp_vec(1, 1'b1, 1'b0));
        r_in = 1'b0; ph[0] = 1'b0;
        @(negedge clk);
        step(0);
        check("R8", "next group", int'(col_pulse), exp_vec(2, 1'b1, 1'b0));

        // R1: reset mid-run clears chain and pending start
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "mid reset chain", int'(col_pulse), 0);
        r_in = 1'b1; @(negedge clk); r_in = 1'b0;
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        step(0);
        check("R1", "pending cleared", int'(col_pulse), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule